// File: doc/BRIEF.md
# Two-Bank Latched Bus Exchanger

This block joins one narrow A bus to two B banks of equal width. Each direction has its own latch stages. Traffic from A can be latched toward bank 1 and toward bank 2 on separate enables. Each bank drives only when its own output enable is active, so A data can go to bank 1, to bank 2, to both, or to neither. Traffic toward A is latched per bank. A select line then picks which of the two held bank words is placed on A. Typical uses are address/data multiplexing and memory interleaving.

The three-state pins are split into a data input, a data output and an output-enable flag, so the block can be synthesized and the pad cell stays outside. Each latch stage is transparent while its enable is high. It holds the word it loaded on the last rising clock edge at which the enable was high, and it resets to zero.

Top module: `bus_exchanger`

## Requirements
- R1: The A port and both bank ports share one width parameter `WIDTH`, which defaults to 12 bits.
- R2: While a latch enable is high, the output fed by that stage equals the stage's input in the same cycle, with no clock delay.
- R3: On each rising clock edge with its enable high, a stage stores its input. While the enable is low, the stage presents the word from the last such edge.
- R4: Bank 1 output comes from the A-to-bank-1 stage (enable `a2b1_le_i`). Bank 2 output comes from the A-to-bank-2 stage (enable `a2b2_le_i`). Each stage loads only on its own enable.
- R5: Toward A, `ret_sel_i`=1 presents the bank-1 return stage (enable `b1a_le_i`) and `ret_sel_i`=0 presents the bank-2 return stage (enable `b2a_le_i`).
- R6: The output enables are active low. A port whose enable input is 1 has its `_oe_o` flag at 0 and its data output forced to all zeros. When the enable input is 0, `_oe_o` is 1 and the data is driven.
- R7: `b1_oe_ni` and `b2_oe_ni` act independently, so all four combinations (neither, bank 1 only, bank 2 only, both) are reachable.
- R8: An active-low asynchronous reset `rst_ni` clears all four stages to zero.
- R9: A load in one direction never changes what is held for the other direction, and a load for one bank never changes the other bank's stage.
- R10: Two different words written from A into the two banks can be returned through the two return stages and read back on A, each through the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; stages load on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_d_i | input | WIDTH | Data arriving on the A bus |
| a_d_o | output | WIDTH | Data driven onto the A bus |
| a_oe_o | output | 1 | A bus drive enable, active high |
| b1_d_i | input | WIDTH | Data arriving on bank 1 |
| b1_d_o | output | WIDTH | Data driven onto bank 1 |
| b1_oe_o | output | 1 | Bank 1 drive enable |
| b2_d_i | input | WIDTH | Data arriving on bank 2 |
| b2_d_o | output | WIDTH | Data driven onto bank 2 |
| b2_oe_o | output | 1 | Bank 2 drive enable |
| a2b1_le_i | input | 1 | Latch enable, A toward bank 1 |
| a2b2_le_i | input | 1 | Latch enable, A toward bank 2 |
| b1a_le_i | input | 1 | Latch enable, bank 1 toward A |
| b2a_le_i | input | 1 | Latch enable, bank 2 toward A |
| ret_sel_i | input | 1 | Return select: 1 picks bank 1, 0 picks bank 2 |
| a_oe_ni | input | 1 | A drive enable, active low |
| b1_oe_ni | input | 1 | Bank 1 drive enable, active low |
| b2_oe_ni | input | 1 | Bank 2 drive enable, active low |

## Verification
The bench writes two different words into the two banks on separate pulses and returns them through the select. A design that shared or swapped a stage would read back the wrong bank's word, and a design that inverted the select would show it at once. Transparency is checked in the same cycle the enable rises. A design that added a register delay would show the previous word. Hold is checked across long runs with the enable low, where a stage that keeps loading would follow the input. Each output enable is checked in both states, and a disabled port must show zeros rather than its held data.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned NUM_BANKS = 2;
  typedef enum logic {
    RET_BANK2 = 1'b0,
    RET_BANK1 = 1'b1
  } ret_sel_e;
endpackage

// File: rtl/xlat_stage.sv
module xlat_stage #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             le_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   held_q <= '0;
    else if (le_i) held_q <= d_i;
  end

  // transparent while enabled
  assign q_o = le_i ? d_i : held_q;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && $past(!le_i)) |-> $stable(q_o));
endmodule

// File: rtl/xlat_ret_mux.sv
module xlat_ret_mux
  import xlat_pkg::*;
#(
  parameter int unsigned WIDTH = 12
) (
  input  logic [NUM_BANKS-1:0][WIDTH-1:0] ret_i,
  input  logic                            sel_i,
  output logic [WIDTH-1:0]                y_o
);
  ret_sel_e sel;
  assign sel = ret_sel_e'(sel_i);

  always_comb begin
    unique case (sel)
      RET_BANK1: y_o = ret_i[0];
      default:   y_o = ret_i[1];
    endcase
  end
endmodule

// File: rtl/xlat_drive.sv
module xlat_drive #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             oe_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] d_o,
  output logic             oe_o
);
  assign oe_o = ~oe_ni;
  assign d_o  = oe_ni ? '0 : d_i;
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import xlat_pkg::*;
#(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_d_i,
  output logic [WIDTH-1:0] a_d_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b1_d_i,
  output logic [WIDTH-1:0] b1_d_o,
  output logic             b1_oe_o,
  input  logic [WIDTH-1:0] b2_d_i,
  output logic [WIDTH-1:0] b2_d_o,
  output logic             b2_oe_o,
  input  logic             a2b1_le_i,
  input  logic             a2b2_le_i,
  input  logic             b1a_le_i,
  input  logic             b2a_le_i,
  input  logic             ret_sel_i,
  input  logic             a_oe_ni,
  input  logic             b1_oe_ni,
  input  logic             b2_oe_ni
);
  logic [NUM_BANKS-1:0][WIDTH-1:0] bank_in, fwd_q, ret_q, bank_out;
  logic [NUM_BANKS-1:0]            fwd_le, ret_le, bank_oe_n, bank_oe;
  logic [WIDTH-1:0]                ret_y;

  assign bank_in   = {b2_d_i, b1_d_i};
  assign fwd_le    = {a2b2_le_i, a2b1_le_i};
  assign ret_le    = {b2a_le_i, b1a_le_i};
  assign bank_oe_n = {b2_oe_ni, b1_oe_ni};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    xlat_stage #(.WIDTH(WIDTH)) u_fwd (
      .clk_i(clk_i), .rst_ni(rst_ni), .le_i(fwd_le[b]),
      .d_i(a_d_i), .q_o(fwd_q[b])
    );
    xlat_stage #(.WIDTH(WIDTH)) u_ret (
      .clk_i(clk_i), .rst_ni(rst_ni), .le_i(ret_le[b]),
      .d_i(bank_in[b]), .q_o(ret_q[b])
    );
    xlat_drive #(.WIDTH(WIDTH)) u_drv (
      .oe_ni(bank_oe_n[b]), .d_i(fwd_q[b]),
      .d_o(bank_out[b]), .oe_o(bank_oe[b])
    );
  end

  xlat_ret_mux #(.WIDTH(WIDTH)) u_mux (
    .ret_i(ret_q), .sel_i(ret_sel_i), .y_o(ret_y)
  );

  xlat_drive #(.WIDTH(WIDTH)) u_a_drv (
    .oe_ni(a_oe_ni), .d_i(ret_y), .d_o(a_d_o), .oe_o(a_oe_o)
  );

  assign b1_d_o  = bank_out[0];
  assign b2_d_o  = bank_out[1];
  assign b1_oe_o = bank_oe[0];
  assign b2_oe_o = bank_oe[1];

  p_transparent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a2b1_le_i && !b1_oe_ni) |-> (b1_d_o == a_d_i));
  p_route_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b1a_le_i && ret_sel_i && !a_oe_ni) |-> (a_d_o == b1_d_i));
  p_hiz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_oe_ni |-> (a_d_o == '0 && !a_oe_o));
  p_indep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a2b1_le_i && !b1_oe_ni && $past(!a2b1_le_i) && $past(!b1_oe_ni))
      |-> $stable(b1_d_o));
endmodule

// File: tb/bus_exchanger_bench.sv
module bus_exchanger_bench;
  localparam int W = 12;
  logic clk = 0, rst_n = 0, run = 0;
  always #5 clk = ~clk;

  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic le_a1 = 0, le_a2 = 0, le_r1 = 0, le_r2 = 0, sel = 0;
  logic oea_n = 0, oe1_n = 0, oe2_n = 0;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_oe, b1_oe, b2_oe;
  int checks = 0, fails = 0;

  bus_exchanger #(.WIDTH(W)) u_bus_exchanger (
    .clk_i(clk), .rst_ni(rst_n),
    .a_d_i(a_in), .a_d_o(a_out), .a_oe_o(a_oe),
    .b1_d_i(b1_in), .b1_d_o(b1_out), .b1_oe_o(b1_oe),
    .b2_d_i(b2_in), .b2_d_o(b2_out), .b2_oe_o(b2_oe),
    .a2b1_le_i(le_a1), .a2b2_le_i(le_a2), .b1a_le_i(le_r1), .b2a_le_i(le_r2),
    .ret_sel_i(sel), .a_oe_ni(oea_n), .b1_oe_ni(oe1_n), .b2_oe_ni(oe2_n)
  );

  // reference model: four held words
  logic [W-1:0] m_a1, m_a2, m_r1, m_r2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a1 <= '0; m_a2 <= '0; m_r1 <= '0; m_r2 <= '0;
    end else begin
      if (le_a1) m_a1 <= a_in;
      if (le_a2) m_a2 <= a_in;
      if (le_r1) m_r1 <= b1_in;
      if (le_r2) m_r2 <= b2_in;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [W-1:0] e1, e2, ea, r1, r2;
    e1 = le_a1 ? a_in : m_a1;
    e2 = le_a2 ? a_in : m_a2;
    r1 = le_r1 ? b1_in : m_r1;
    r2 = le_r2 ? b2_in : m_r2;
    ea = sel ? r1 : r2;
    chk("R4 bank1 data", b1_out, oe1_n ? '0 : e1);
    chk("R4 bank2 data", b2_out, oe2_n ? '0 : e2);
    chk("R5 A data", a_out, oea_n ? '0 : ea);
    chk("R6 A oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, ~oea_n});
    chk("R7 bank1 oe", {{(W-1){1'b0}}, b1_oe}, {{(W-1){1'b0}}, ~oe1_n});
    chk("R7 bank2 oe", {{(W-1){1'b0}}, b2_oe}, {{(W-1){1'b0}}, ~oe2_n});
  endtask

  always @(negedge clk) if (run) compare_all();

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R8: reset clears all stages, ports enabled
    #1;
    chk("R8 reset bank1", b1_out, '0);
    chk("R8 reset bank2", b2_out, '0);
    chk("R8 reset A", a_out, '0);
    tick(); tick();
    rst_n = 1; run = 1;
    tick();

    // R2: transparency in the same cycle; R1 full width
    le_a1 = 1; a_in = 12'hFFF; #1;
    chk("R2 R1 transparent full width", b1_out, 12'hFFF);
    tick();

    // R10 interleave: two words into two banks on separate pulses
    a_in = 12'h5A5; tick(); le_a1 = 0;
    a_in = 12'h3C3; le_a2 = 1; tick(); le_a2 = 0;
    a_in = 12'h0F0; tick(); tick();
    chk("R3 R4 bank1 held", b1_out, 12'h5A5);
    chk("R3 R4 bank2 held", b2_out, 12'h3C3);
    // return the driven bank words toward A
    b1_in = b1_out; b2_in = b2_out;
    le_r1 = 1; tick(); le_r1 = 0; b1_in = 12'h111;
    le_r2 = 1; tick(); le_r2 = 0; b2_in = 12'h222;
    tick();
    sel = 1; #1; chk("R10 R5 bank1 word on A", a_out, 12'h5A5);
    tick();
    sel = 0; #1; chk("R10 R5 bank2 word on A", a_out, 12'h3C3);
    // R9: return loads left forward stages alone
    chk("R9 bank1 after return load", b1_out, 12'h5A5);
    chk("R9 bank2 after return load", b2_out, 12'h3C3);
    tick();

    // R6 and R7: every enable combination
    for (int k = 0; k < 8; k++) begin
      {oea_n, oe1_n, oe2_n} = k[2:0];
      #1;
      chk("R6 A disabled zero", a_out, oea_n ? '0 : 12'h3C3);
      chk("R7 bank1 combo", b1_out, oe1_n ? '0 : 12'h5A5);
      chk("R7 bank2 combo", b2_out, oe2_n ? '0 : 12'h3C3);
      tick();
    end
    {oea_n, oe1_n, oe2_n} = 3'b000;

    // random traffic compared every cycle against the model
    for (int i = 0; i < 400; i++) begin
      a_in = W'($urandom); b1_in = W'($urandom); b2_in = W'($urandom);
      {le_a1, le_a2, le_r1, le_r2} = 4'($urandom) & 4'($urandom);
      sel = 1'($urandom);
      {oea_n, oe1_n, oe2_n} = 3'($urandom) & 3'($urandom);
      tick();
    end

    // R8: asynchronous reset mid-run clears held words
    {le_a1, le_a2, le_r1, le_r2} = 4'b0;
    {oea_n, oe1_n, oe2_n} = 3'b000;
    tick();
    run = 0; rst_n = 0; #1;
    chk("R8 async clear bank1", b1_out, '0);
    chk("R8 async clear A", a_out, '0);
    tick(); rst_n = 1; run = 1; tick(); tick();
    finish_run();
  end
endmodule